// File: doc/BRIEF.md
# Phase Comparator with Backlash Pulse and Qualified Lock Detect

This block compares two divider pulses, the reference pulse and the main-loop pulse, in the clock domain of the reference input clock. A rising edge on the reference pulse raises the UP pump request. A rising edge on the main pulse raises the DOWN pump request. Once both requests are high, both stay high for a fixed backlash interval and then drop together. Because both requests are therefore on for a minimum time in every comparison, the charge pump has no dead zone near zero phase error.

Each finished comparison is graded. It counts as locked only if both edges land in the same reference-clock period, which means the phase error is below one reference period. A qualification counter needs a run of locked comparisons before the lock level rises, and one bad comparison drops it. The main-loop lock is combined with an auxiliary loop's lock indication. A powered-down auxiliary loop is left out of the decision, and a powered-down main loop forces the lock level low. The lock pin can be driven push-pull or as open drain. A small decoder also turns the pump-current select bit and the speed-up state into a current multiplier code for the analog pump.

Top module: `pfd_backlash_lock`

## Requirements
- R1: A rising edge (0 then 1 over two samples) of `ref_pulse` sets `pump_up`, and a rising edge of `main_pulse` sets `pump_dn`. Once both are set, they are cleared in the same cycle.
- R2: When both edges are sampled on the same clock edge, `pump_up` and `pump_dn` are high together for exactly BACKLASH cycles (default 2).
- R3: If one edge leads the other by k cycles, the leading output stays high for k+BACKLASH cycles and the lagging output for BACKLASH cycles.
- R4: A comparison counts as locked only when its two edges are sampled on the same clock edge. The lock level rises on the clock edge that ends the LOCK_RUN-th consecutive locked comparison (default 4). Any comparison with a non-zero gap clears it at that comparison's end.
- R5: While `aux_pd`=1 the value of `aux_lock_in` is ignored. While `aux_pd`=0 the lock level also needs `aux_lock_in`=1, and it follows changes of that input one clock later.
- R6: While `main_pd`=1, the lock level is 0, both pump outputs are 0, divider edges are ignored, and the qualification run restarts from zero. This also gives 0 when both loops are powered down.
- R7: With `od_mode`=0, `lock_oe`=1 and `lock_out` equals the lock level. With `od_mode`=1, `lock_out`=0 and `lock_oe` equals the inverse of the lock level, so the pin is driven only to pull it low.
- R8: `cur_mult` is 3 for `cur_sel`=0 with `speed_up`=0, 15 for `cur_sel`=0 with `speed_up`=1, 1 for `cur_sel`=1 with `speed_up`=0, and 5 for `cur_sel`=1 with `speed_up`=1.
- R9: After reset both pump outputs and the lock level are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock, used as the sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | Reference divider output pulse |
| main_pulse | input | 1 | Main divider output pulse |
| main_pd | input | 1 | Main loop powered down |
| aux_pd | input | 1 | Auxiliary loop powered down |
| aux_lock_in | input | 1 | Lock indication of the auxiliary loop |
| od_mode | input | 1 | Lock pin mode: 0 push-pull, 1 open drain |
| cur_sel | input | 1 | Pump-current select bit |
| speed_up | input | 1 | Pump speed-up mode active |
| pump_up | output | 1 | UP pump request |
| pump_dn | output | 1 | DOWN pump request |
| lock_out | output | 1 | Lock pin data |
| lock_oe | output | 1 | Lock pin output enable |
| cur_mult | output | 4 | Pump-current multiplier code |

## Verification
The hardest behaviour to reach from the ports is the qualified lock level. It builds on a whole run of comparisons, then has to fall again on a single comparison that is off by one cycle. A second case of the same kind is the restart of the run after a main-loop power-down. The stimulus places each pair of divider edges at a chosen negative-edge offset inside a fixed window, so every comparison is known to have finished before the next one starts. The lock level is checked after the third and after the fourth zero-gap comparison, then after a one-cycle-gap comparison, and again after a power-down and three fresh comparisons. The pump widths are measured by counting high samples across the window, so they do not depend on picking the exact cycle.

// File: rtl/pfd_backlash_lock_pkg.sv
package pfd_backlash_lock_pkg;
    localparam int MULT_W = 4;
    localparam logic [MULT_W-1:0] MULT_HI_NORM = 4'd3;
    localparam logic [MULT_W-1:0] MULT_HI_FAST = 4'd15;
    localparam logic [MULT_W-1:0] MULT_LO_NORM = 4'd1;
    localparam logic [MULT_W-1:0] MULT_LO_FAST = 4'd5;
endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
    parameter int BACKLASH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ref_pulse,
    input  logic main_pulse,
    output logic up,
    output logic dn,
    output logic cmp_done,
    output logic cmp_ok
);
    localparam int BLW = (BACKLASH > 1) ? $clog2(BACKLASH) : 1;
    localparam logic [BLW-1:0] BL_LAST = BLW'(BACKLASH - 1);

    typedef struct packed {
        logic           ref_s;
        logic           main_s;
        logic           up;
        logic           dn;
        logic [BLW-1:0] bl_cnt;
        logic           err_seen;
    } pfd_st_t;

    pfd_st_t st_q, st_d;
    logic    ref_rise, main_rise, done_c;

    always_comb begin
        st_d        = st_q;
        st_d.ref_s  = ref_pulse;
        st_d.main_s = main_pulse;
        ref_rise    = ref_pulse & ~st_q.ref_s;
        main_rise   = main_pulse & ~st_q.main_s;
        done_c      = 1'b0;
        if (st_q.up && st_q.dn) begin
            if (st_q.bl_cnt == BL_LAST) begin
                done_c        = 1'b1;
                st_d.up       = ref_rise;
                st_d.dn       = main_rise;
                st_d.bl_cnt   = '0;
                st_d.err_seen = 1'b0;
            end else begin
                st_d.bl_cnt = st_q.bl_cnt + 1'b1;
            end
        end else begin
            st_d.up = st_q.up | ref_rise;
            st_d.dn = st_q.dn | main_rise;
            if (st_q.up ^ st_q.dn) begin
                st_d.err_seen = 1'b1;
            end
        end
        if (!enable) begin
            st_d.up       = 1'b0;
            st_d.dn       = 1'b0;
            st_d.bl_cnt   = '0;
            st_d.err_seen = 1'b0;
            done_c        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up       = st_q.up;
    assign dn       = st_q.dn;
    assign cmp_done = done_c;
    assign cmp_ok   = ~st_q.err_seen;
endmodule

// File: rtl/lock_qual.sv
module lock_qual #(
    parameter int LOCK_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_pd,
    input  logic aux_pd,
    input  logic aux_lock_in,
    input  logic cmp_done,
    input  logic cmp_ok,
    output logic lock_level
);
    localparam int CW = $clog2(LOCK_RUN + 1);
    localparam logic [CW-1:0] RUN_FULL = CW'(LOCK_RUN);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          lock;
    } lq_st_t;

    lq_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (main_pd) begin
            st_d.run = '0;
        end else if (cmp_done) begin
            if (!cmp_ok) begin
                st_d.run = '0;
            end else if (st_q.run != RUN_FULL) begin
                st_d.run = st_q.run + 1'b1;
            end
        end
        st_d.lock = !main_pd && (st_d.run == RUN_FULL) && (aux_pd || aux_lock_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_level = st_q.lock;
endmodule

// File: rtl/pump_gain.sv
module pump_gain
    import pfd_backlash_lock_pkg::*;
(
    input  logic              cur_sel,
    input  logic              speed_up,
    output logic [MULT_W-1:0] cur_mult
);
    always_comb begin
        unique case ({cur_sel, speed_up})
            2'b00:   cur_mult = MULT_HI_NORM;
            2'b01:   cur_mult = MULT_HI_FAST;
            2'b10:   cur_mult = MULT_LO_NORM;
            default: cur_mult = MULT_LO_FAST;
        endcase
    end
endmodule

// File: rtl/pfd_backlash_lock.sv
module pfd_backlash_lock
    import pfd_backlash_lock_pkg::*;
#(
    parameter int BACKLASH = 2,
    parameter int LOCK_RUN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              main_pulse,
    input  logic              main_pd,
    input  logic              aux_pd,
    input  logic              aux_lock_in,
    input  logic              od_mode,
    input  logic              cur_sel,
    input  logic              speed_up,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              lock_out,
    output logic              lock_oe,
    output logic [MULT_W-1:0] cur_mult
);
    logic cmp_done, cmp_ok, lock_level;

    pfd_core #(.BACKLASH(BACKLASH)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (~main_pd),
        .ref_pulse  (ref_pulse),
        .main_pulse (main_pulse),
        .up         (pump_up),
        .dn         (pump_dn),
        .cmp_done   (cmp_done),
        .cmp_ok     (cmp_ok)
    );

    lock_qual #(.LOCK_RUN(LOCK_RUN)) qual_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_pd     (main_pd),
        .aux_pd      (aux_pd),
        .aux_lock_in (aux_lock_in),
        .cmp_done    (cmp_done),
        .cmp_ok      (cmp_ok),
        .lock_level  (lock_level)
    );

    pump_gain gain_i (
        .cur_sel  (cur_sel),
        .speed_up (speed_up),
        .cur_mult (cur_mult)
    );

    always_comb begin
        if (od_mode) begin
            lock_out = 1'b0;
            lock_oe  = ~lock_level;
        end else begin
            lock_out = lock_level;
            lock_oe  = 1'b1;
        end
    end
endmodule

// File: rtl/pfd_backlash_lock_chk.sv
module pfd_backlash_lock_chk #(
    parameter int BACKLASH = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       main_pd,
    input logic       od_mode,
    input logic       cur_sel,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       lock_out,
    input logic       lock_oe,
    input logic       lock_level,
    input logic [3:0] cur_mult
);
    // R1
    up_falls_with_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_up) |-> ($past(pump_dn) || $past(main_pd)));

    // R1
    dn_falls_with_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_dn) |-> ($past(pump_up) || $past(main_pd)));

    generate
        if (BACKLASH >= 2) begin : g_min_on
            // R2
            up_min_on_chk: assert property (@(posedge clk) disable iff (!rst_n || main_pd)
                $rose(pump_up) |=> pump_up);
            // R2
            dn_min_on_chk: assert property (@(posedge clk) disable iff (!rst_n || main_pd)
                $rose(pump_dn) |=> pump_dn);
        end
    endgenerate

    // R6
    pd_clears_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_pd |=> (!lock_level && !pump_up && !pump_dn));

    // R7
    oe_low_only_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_oe |-> od_mode);

    // R7
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        od_mode |-> !lock_out);

    // R8
    low_sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_sel |-> (cur_mult <= 4'd5));
endmodule

bind pfd_backlash_lock pfd_backlash_lock_chk #(.BACKLASH(BACKLASH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .main_pd    (main_pd),
    .od_mode    (od_mode),
    .cur_sel    (cur_sel),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .lock_out   (lock_out),
    .lock_oe    (lock_oe),
    .lock_level (lock_level),
    .cur_mult   (cur_mult)
);

// File: tb/pfd_backlash_lock_tb_top.sv
`timescale 1ns/1ps
module pfd_backlash_lock_tb_top;
    localparam int BL = 2;
    localparam int RUN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_pulse = 1'b0, main_pulse = 1'b0;
    logic       main_pd = 1'b0, aux_pd = 1'b1, aux_lock_in = 1'b0;
    logic       od_mode = 1'b0, cur_sel = 1'b0, speed_up = 1'b0;
    logic       pump_up, pump_dn, lock_out, lock_oe;
    logic [3:0] cur_mult;

    int n_checks = 0;
    int n_fail = 0;
    int up_cnt, dn_cnt, both_cnt;

    always #2 clk = ~clk;

    pfd_backlash_lock #(.BACKLASH(BL), .LOCK_RUN(RUN)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .main_pulse(main_pulse),
        .main_pd(main_pd), .aux_pd(aux_pd), .aux_lock_in(aux_lock_in),
        .od_mode(od_mode), .cur_sel(cur_sel), .speed_up(speed_up),
        .pump_up(pump_up), .pump_dn(pump_dn), .lock_out(lock_out),
        .lock_oe(lock_oe), .cur_mult(cur_mult)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // k > 0: reference leads by k cycles; k < 0: main leads by -k cycles
    task automatic compare(input int k);
        int ref_at, main_at;
        ref_at  = 2 + ((k < 0) ? -k : 0);
        main_at = 2 + ((k > 0) ? k : 0);
        up_cnt = 0; dn_cnt = 0; both_cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pump_up) up_cnt++;
            if (pump_dn) dn_cnt++;
            if (pump_up && pump_dn) both_cnt++;
            ref_pulse  = (i == ref_at);
            main_pulse = (i == main_at);
        end
    endtask

    task automatic t_reset;
        check("R9 pump_up after reset", pump_up, 0);
        check("R9 pump_dn after reset", pump_dn, 0);
        check("R9 lock_out after reset", lock_out, 0);
        check("R7 lock_oe push-pull", lock_oe, 1);
    endtask

    task automatic t_widths;
        compare(0);
        check("R2 zero gap both high", both_cnt, BL);
        check("R1 zero gap up", up_cnt, BL);
        compare(3);
        check("R3 ref leads up width", up_cnt, 3 + BL);
        check("R3 ref leads dn width", dn_cnt, BL);
        check("R1 overlap", both_cnt, BL);
        compare(-5);
        check("R3 main leads dn width", dn_cnt, 5 + BL);
        check("R3 main leads up width", up_cnt, BL);
    endtask

    task automatic t_lock_run;
        compare(1);  // clears any earlier run
        for (int j = 0; j < RUN - 1; j++) compare(0);
        check("R4 lock low before full run", lock_out, 0);
        compare(0);
        check("R4 lock high after full run", lock_out, 1);
        compare(0);
        check("R4 lock stays high", lock_out, 1);
        compare(1);
        check("R4 one-cycle gap drops lock", lock_out, 0);
        compare(0);
        check("R4 run restarted", lock_out, 0);
    endtask

    task automatic t_aux;
        for (int j = 0; j < RUN; j++) compare(0);
        check("R5 aux off main locked", lock_out, 1);
        @(negedge clk); aux_pd = 1'b0; aux_lock_in = 1'b0;
        @(negedge clk);
        check("R5 aux on unlocked", lock_out, 0);
        aux_lock_in = 1'b1;
        @(negedge clk);
        check("R5 aux on locked", lock_out, 1);
        aux_pd = 1'b1; aux_lock_in = 1'b0;
        @(negedge clk);
        check("R5 aux off ignores its lock", lock_out, 1);
    endtask

    task automatic t_od;
        // lock level is 1 on entry
        od_mode = 1'b1; #1;
        check("R7 od high level data", lock_out, 0);
        check("R7 od high level oe", lock_oe, 0);
        compare(2);
        check("R7 od low level oe", lock_oe, 1);
        check("R7 od low level data", lock_out, 0);
        od_mode = 1'b0; #1;
        check("R7 push-pull low", lock_out, 0);
        check("R7 push-pull oe", lock_oe, 1);
    endtask

    task automatic t_pd;
        for (int j = 0; j < RUN; j++) compare(0);
        check("R4 relock", lock_out, 1);
        @(negedge clk); main_pd = 1'b1;
        @(negedge clk);
        check("R6 main pd lock", lock_out, 0);
        compare(2);
        check("R6 pd ignores ref edge", up_cnt, 0);
        check("R6 pd ignores main edge", dn_cnt, 0);
        aux_pd = 1'b1;
        check("R6 both pd lock", lock_out, 0);
        @(negedge clk); main_pd = 1'b0;
        for (int j = 0; j < RUN - 1; j++) compare(0);
        check("R6 run restarts after pd", lock_out, 0);
        compare(0);
        check("R6 relock after pd", lock_out, 1);
    endtask

    task automatic t_mult;
        for (int s = 0; s < 4; s++) begin
            int exp;
            @(negedge clk);
            cur_sel = s[1]; speed_up = s[0];
            #1;
            exp = (s == 0) ? 3 : (s == 1) ? 15 : (s == 2) ? 1 : 5;
            check("R8 current multiplier", int'(cur_mult), exp);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_widths();
                t_lock_run();
                t_aux();
                t_od();
                t_pd();
                t_mult();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule